// File: doc/BRIEF.md
# Supply Voltage Detector Control Interface

This block is the digital side of a supply-voltage monitor. An analog comparator outside the block reports one bit, set when the supply is below a programmable level. The block decides when that bit is sampled, keeps the latest sample, and raises a sticky low-voltage flag. It can forward that flag to the interrupt controller, subject to a mask bit.

Sampling is paced by a detector tick. The tick comes from one of two sources:
- a fast system clock divided down by a parameterised ratio (512 by default);
- the rising edges of a slow oscillator input, synchronised into the system clock domain.

Software reaches the block through an 8-bit register bus. Using that bus it can:
- choose the tick source;
- gate the tick;
- turn detection on or off;
- program a 4-bit comparison level, which is driven straight out to the analog reference;
- read the result;
- mask the interrupt;
- clear the flag by writing a one to it.

Top module: `supmon_ctrl`

## Requirements
- R1: After reset the registers read as follows: clock control 0x02 (slow source selected, tick gate off), and enable, level, result, mask and flag 0x00. The output irq_o is 0.
- R2: Reserved bits read as 0, and writes to them are ignored. Writing 0xFF gives these read values: clock control 0x03, enable 0x01, mask 0x01, level 0x0F. The level field in bits 3:0 appears on level_o.
- R3: The register offsets are: clock control 0x066, enable 0x100, level 0x101, result 0x102, mask 0x103, flag 0x104. Any other offset reads 0x00, and writes to it change nothing.
- R4: When clock control bit 1 is 0, a detector tick occurs once every 512 system clock cycles. Consecutive flag settings are therefore exactly 512 cycles apart.
- R5: When clock control bit 1 is 1, a tick occurs on each rising edge of slow_osc_i. The edge passes a two-flop synchroniser first. The tick that follows an edge registers on the third system clock edge after the input rises.
- R6: No sampling takes place unless both clock control bit 0 (tick gate) and enable bit 0 are 1. Otherwise the result and the flag hold their values.
- R7: On an enabled tick, result bit 0 takes the synchronised comparator value, where 1 means low voltage. When the supply recovers, the result returns to 0.
- R8: A sampled 1 sets flag bit 0. The flag remains 1 until software writes 1 to flag bit 0. Writing 0 has no effect, and supply recovery does not clear it.
- R9: If a flag-setting sample and a clear write land in the same cycle, the flag ends up set.
- R10: irq_o is 1 exactly when flag bit 0 and mask bit 0 are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System (fast) clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| slow_osc_i | input | 1 | Slow oscillator, asynchronous to clk |
| cmp_low_i | input | 1 | Comparator output, 1 = supply below level |
| bus_addr_i | input | 9 | Register byte offset |
| bus_wr_i | input | 1 | Write strobe, one write per cycle |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data for bus_addr_i (combinational) |
| level_o | output | 4 | Comparison level to the reference ladder |
| irq_o | output | 1 | Interrupt request |

## Verification
The detector is run three ways:
- With a constant low comparator in divided-clock mode. The spacing between flag settings must be exactly 512 cycles, which separates a correct divider from an off-by-one divider.
- With a bench-generated slow oscillator of 24-cycle period. The spacing must match that period, which shows the source select really switches.
- With each enable off in turn. The flag must stay 0 across more than two divider periods, which proves that each of the two gates blocks sampling on its own.

A comparator that returns high after a detection separates a result that tracks the input from a flag that stays sticky. A clear write placed on the exact cycle of a slow-mode tick checks the set-over-clear priority.

// File: rtl/supmon_pkg.sv
package supmon_pkg;

   localparam int unsigned DATA_W = 8;

   // register byte offsets on the bus
   localparam int unsigned OFS_CLK   = 'h066;
   localparam int unsigned OFS_EN    = 'h100;
   localparam int unsigned OFS_LEVEL = 'h101;
   localparam int unsigned OFS_RES   = 'h102;
   localparam int unsigned OFS_MASK  = 'h103;
   localparam int unsigned OFS_FLAG  = 'h104;

   typedef struct packed {
      logic src_slow;  // 1: slow oscillator edges, 0: divided fast clock
      logic tick_on;   // tick gate
      logic det_on;    // detection enable
      logic irq_mask;  // interrupt mask
   } supmon_cfg_t;

endpackage

// File: rtl/supmon_sync.sv
module supmon_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_i,
   output logic q_o
);

   initial begin
      assert (STAGES >= 2) else $fatal(1, "synchroniser needs at least two stages");
   end

   logic [STAGES-1:0] chain_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= '0;
      else        chain_q <= {chain_q[STAGES-2:0], d_i};
   end

   assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/supmon_tick_gen.sv
module supmon_tick_gen #(
   parameter int unsigned DIV_RATIO   = 512,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic slow_osc_i,
   input  logic src_slow_i,
   output logic tick_o
);

   localparam int unsigned CNT_W = (DIV_RATIO > 2) ? $clog2(DIV_RATIO) : 1;
   localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DIV_RATIO - 1);
   localparam bit IS_POW2 = ((DIV_RATIO & (DIV_RATIO - 1)) == 0);

   initial begin
      assert (DIV_RATIO >= 2) else $fatal(1, "DIV_RATIO must be at least 2");
   end

   // divided fast-clock tick
   logic [CNT_W-1:0] div_cnt_q;
   logic             fast_tick;

   assign fast_tick = (div_cnt_q == CNT_LAST);

   generate
      if (IS_POW2) begin : g_div_wrap
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) div_cnt_q <= '0;
            else        div_cnt_q <= div_cnt_q + 1'b1;
         end
      end else begin : g_div_cmp
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)         div_cnt_q <= '0;
            else if (fast_tick) div_cnt_q <= '0;
            else                div_cnt_q <= div_cnt_q + 1'b1;
         end
      end
   endgenerate

   // slow oscillator edge tick
   logic osc_sync;
   logic osc_prev_q;
   logic slow_tick;

   supmon_sync #(.STAGES(SYNC_STAGES)) osc_sync_i (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (slow_osc_i),
      .q_o   (osc_sync)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) osc_prev_q <= 1'b0;
      else        osc_prev_q <= osc_sync;
   end

   assign slow_tick = osc_sync & ~osc_prev_q;
   assign tick_o    = src_slow_i ? slow_tick : fast_tick;

   // R4
   fast_tick_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fast_tick |=> !fast_tick);

   // R5
   slow_tick_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      slow_tick |=> !slow_tick);

endmodule

// File: rtl/supmon_detect.sv
module supmon_detect (
   input  logic clk,
   input  logic rst_n,
   input  logic tick_i,
   input  logic tick_on_i,
   input  logic det_on_i,
   input  logic cmp_low_i,
   input  logic clr_req_i,
   output logic result_o,
   output logic flag_o
);

   logic sample_en;
   logic set_evt;

   assign sample_en = tick_i & tick_on_i & det_on_i;
   assign set_evt   = sample_en & cmp_low_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         result_o <= 1'b0;
         flag_o   <= 1'b0;
      end else begin
         if (sample_en) result_o <= cmp_low_i;
         if (set_evt)        flag_o <= 1'b1;
         else if (clr_req_i) flag_o <= 1'b0;
      end
   end

   // R6
   gated_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(tick_i && tick_on_i && det_on_i) |=> $stable(result_o));

   // R8
   flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_o && !clr_req_i) |=> flag_o);

   // R9
   set_priority_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tick_i && tick_on_i && det_on_i && cmp_low_i) |=> flag_o);

endmodule

// File: rtl/supmon_regs.sv
module supmon_regs
   import supmon_pkg::*;
#(
   parameter int unsigned ADDR_W  = 9,
   parameter int unsigned LEVEL_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr_i,
   input  logic              bus_wr_i,
   input  logic [DATA_W-1:0] bus_wdata_i,
   input  logic              result_i,
   input  logic              flag_i,
   output supmon_cfg_t       cfg_o,
   output logic [LEVEL_W-1:0] level_o,
   output logic              clr_req_o,
   output logic [DATA_W-1:0] bus_rdata_o
);

   initial begin
      assert (LEVEL_W >= 1 && LEVEL_W <= DATA_W) else $fatal(1, "LEVEL_W out of range");
      assert ((1 << ADDR_W) > OFS_FLAG) else $fatal(1, "ADDR_W too narrow for map");
   end

   logic hit_clk, hit_en, hit_lvl, hit_res, hit_msk, hit_flg;

   assign hit_clk = (bus_addr_i == ADDR_W'(OFS_CLK));
   assign hit_en  = (bus_addr_i == ADDR_W'(OFS_EN));
   assign hit_lvl = (bus_addr_i == ADDR_W'(OFS_LEVEL));
   assign hit_res = (bus_addr_i == ADDR_W'(OFS_RES));
   assign hit_msk = (bus_addr_i == ADDR_W'(OFS_MASK));
   assign hit_flg = (bus_addr_i == ADDR_W'(OFS_FLAG));

   logic unused_wbits;
   assign unused_wbits = ^bus_wdata_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_o   <= '{src_slow: 1'b1, tick_on: 1'b0, det_on: 1'b0, irq_mask: 1'b0};
         level_o <= '0;
      end else if (bus_wr_i) begin
         if (hit_clk) begin
            cfg_o.src_slow <= bus_wdata_i[1];
            cfg_o.tick_on  <= bus_wdata_i[0];
         end
         if (hit_en)  cfg_o.det_on   <= bus_wdata_i[0];
         if (hit_msk) cfg_o.irq_mask <= bus_wdata_i[0];
         if (hit_lvl) level_o        <= bus_wdata_i[LEVEL_W-1:0];
      end
   end

   assign clr_req_o = bus_wr_i & hit_flg & bus_wdata_i[0];

   always_comb begin
      bus_rdata_o = '0;
      if (hit_clk) begin
         bus_rdata_o[1] = cfg_o.src_slow;
         bus_rdata_o[0] = cfg_o.tick_on;
      end
      if (hit_en)  bus_rdata_o[0]           = cfg_o.det_on;
      if (hit_lvl) bus_rdata_o[LEVEL_W-1:0] = level_o;
      if (hit_res) bus_rdata_o[0]           = result_i;
      if (hit_msk) bus_rdata_o[0]           = cfg_o.irq_mask;
      if (hit_flg) bus_rdata_o[0]           = flag_i;
   end

   // R2
   reserved_en_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hit_en |-> (bus_rdata_o[DATA_W-1:1] == '0));

   // R3
   unmapped_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(hit_clk || hit_en || hit_lvl || hit_res || hit_msk || hit_flg) |-> (bus_rdata_o == '0));

endmodule

// File: rtl/supmon_ctrl.sv
module supmon_ctrl
   import supmon_pkg::*;
#(
   parameter int unsigned ADDR_W      = 9,
   parameter int unsigned DIV_RATIO   = 512,
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned LEVEL_W     = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               slow_osc_i,
   input  logic               cmp_low_i,
   input  logic [ADDR_W-1:0]  bus_addr_i,
   input  logic               bus_wr_i,
   input  logic [7:0]         bus_wdata_i,
   output logic [7:0]         bus_rdata_o,
   output logic [LEVEL_W-1:0] level_o,
   output logic               irq_o
);

   supmon_cfg_t cfg;
   logic        tick;
   logic        cmp_sync;
   logic        clr_req;
   logic        result;
   logic        flag;

   supmon_regs #(.ADDR_W(ADDR_W), .LEVEL_W(LEVEL_W)) regs_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .bus_addr_i  (bus_addr_i),
      .bus_wr_i    (bus_wr_i),
      .bus_wdata_i (bus_wdata_i),
      .result_i    (result),
      .flag_i      (flag),
      .cfg_o       (cfg),
      .level_o     (level_o),
      .clr_req_o   (clr_req),
      .bus_rdata_o (bus_rdata_o)
   );

   supmon_tick_gen #(.DIV_RATIO(DIV_RATIO), .SYNC_STAGES(SYNC_STAGES)) tick_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .slow_osc_i (slow_osc_i),
      .src_slow_i (cfg.src_slow),
      .tick_o     (tick)
   );

   supmon_sync #(.STAGES(SYNC_STAGES)) cmp_sync_i (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (cmp_low_i),
      .q_o   (cmp_sync)
   );

   supmon_detect detect_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick_i    (tick),
      .tick_on_i (cfg.tick_on),
      .det_on_i  (cfg.det_on),
      .cmp_low_i (cmp_sync),
      .clr_req_i (clr_req),
      .result_o  (result),
      .flag_o    (flag)
   );

   assign irq_o = flag & cfg.irq_mask;

   // R10
   irq_needs_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |-> flag);

endmodule

// File: tb/supmon_ctrl_tb_top.sv
`timescale 1ns/1ps
module supmon_ctrl_tb_top;

   localparam int unsigned A_CLK = 'h066, A_EN = 'h100, A_LVL = 'h101,
                           A_RES = 'h102, A_MSK = 'h103, A_FLG = 'h104;
   localparam int unsigned OSC_HALF = 12;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       osc_auto = 1'b0, osc_gen = 1'b0, osc_man = 1'b0;
   logic       slow_osc;
   logic       cmp_low = 1'b0;
   logic [8:0] addr = '0;
   logic       wr = 1'b0;
   logic [7:0] wdata = '0;
   logic [7:0] rdata;
   logic [3:0] level;
   logic       irq;

   int unsigned n_run = 0, n_fail = 0;
   int unsigned cyc = 0;

   always #5 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   always begin
      repeat (OSC_HALF) @(negedge clk);
      osc_gen = ~osc_gen;
   end
   assign slow_osc = osc_auto ? osc_gen : osc_man;

   supmon_ctrl dut_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .slow_osc_i  (slow_osc),
      .cmp_low_i   (cmp_low),
      .bus_addr_i  (addr),
      .bus_wr_i    (wr),
      .bus_wdata_i (wdata),
      .bus_rdata_o (rdata),
      .level_o     (level),
      .irq_o       (irq)
   );

   task automatic chk(input string req, input int unsigned act, input int unsigned exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic bus_wr(input int unsigned a, input logic [7:0] d);
      @(negedge clk);
      addr = 9'(a); wdata = d; wr = 1'b1;
      @(negedge clk);
      wr = 1'b0;
   endtask

   task automatic bus_rd(input int unsigned a, output logic [7:0] d);
      @(negedge clk);
      addr = 9'(a);
      #1 d = rdata;
   endtask

   task automatic rd_chk(input string req, input int unsigned a, input int unsigned exp);
      logic [7:0] d;
      bus_rd(a, d);
      chk(req, d, exp);
   endtask

   task automatic wait_flag(output int unsigned at);
      logic [7:0] d;
      at = 0;
      for (int i = 0; i < 3000; i++) begin
         bus_rd(A_FLG, d);
         if (d[0]) begin at = cyc; break; end
      end
   endtask

   task automatic t_reset;
      rd_chk("R1 clk ctrl", A_CLK, 'h02);
      rd_chk("R1 enable", A_EN, 'h00);
      rd_chk("R1 level", A_LVL, 'h00);
      rd_chk("R1 result", A_RES, 'h00);
      rd_chk("R1 mask", A_MSK, 'h00);
      rd_chk("R1 flag", A_FLG, 'h00);
      chk("R1 irq", irq, 0);
   endtask

   task automatic t_regs;
      bus_wr(A_CLK, 'hFC); rd_chk("R2 clk ctrl write FC", A_CLK, 'h00);
      bus_wr(A_CLK, 'hFF); rd_chk("R2 clk ctrl", A_CLK, 'h03);
      bus_wr(A_EN, 'hFF);  rd_chk("R2 enable", A_EN, 'h01);
      bus_wr(A_MSK, 'hFF); rd_chk("R2 mask", A_MSK, 'h01);
      bus_wr(A_LVL, 'hFF); rd_chk("R2 level", A_LVL, 'h0F);
      chk("R2 level_o", level, 'hF);
      bus_wr(A_LVL, 'hA5); rd_chk("R2 level A5", A_LVL, 'h05);
      bus_wr('h050, 'hFF); rd_chk("R3 unmapped", 'h050, 'h00);
      rd_chk("R3 level after unmapped write", A_LVL, 'h05);
      bus_wr(A_CLK, 'h00); bus_wr(A_EN, 'h00); bus_wr(A_MSK, 'h00);
   endtask

   task automatic t_gating;
      cmp_low = 1'b1;
      bus_wr(A_CLK, 'h00); bus_wr(A_EN, 'h01);   // enable only
      repeat (1100) @(negedge clk);
      rd_chk("R6 tick gate off flag", A_FLG, 'h00);
      rd_chk("R6 tick gate off result", A_RES, 'h00);
      bus_wr(A_EN, 'h00); bus_wr(A_CLK, 'h01);   // tick gate only
      repeat (1100) @(negedge clk);
      rd_chk("R6 detect off flag", A_FLG, 'h00);
      rd_chk("R6 detect off result", A_RES, 'h00);
   endtask

   task automatic t_fast;
      int unsigned t0, t1;
      bus_wr(A_EN, 'h01);
      wait_flag(t0);
      chk("R4 first detection seen", (t0 != 0), 1);
      rd_chk("R7 result low", A_RES, 'h01);
      bus_wr(A_FLG, 'h01);
      rd_chk("R8 write 1 clears", A_FLG, 'h00);
      wait_flag(t1);
      chk("R4 divided tick spacing", t1 - t0, 512);
   endtask

   task automatic t_recover;
      cmp_low = 1'b0;
      repeat (1100) @(negedge clk);
      rd_chk("R7 result recovers", A_RES, 'h00);
      rd_chk("R8 flag sticky after recovery", A_FLG, 'h01);
      bus_wr(A_FLG, 'h00);
      rd_chk("R8 write 0 no effect", A_FLG, 'h01);
      chk("R10 masked irq", irq, 0);
      bus_wr(A_MSK, 'h01);
      @(negedge clk); chk("R10 irq flag and mask", irq, 1);
      bus_wr(A_FLG, 'h01);
      @(negedge clk); chk("R10 irq after clear", irq, 0);
   endtask

   task automatic t_slow;
      int unsigned t0, t1;
      bus_wr(A_MSK, 'h00);
      cmp_low = 1'b1;
      osc_auto = 1'b1;
      bus_wr(A_CLK, 'h03);
      wait_flag(t0);
      bus_wr(A_FLG, 'h01);
      wait_flag(t1);
      chk("R5 slow tick spacing", t1 - t0, 2 * OSC_HALF);
   endtask

   task automatic t_priority;
      osc_man = 1'b0;
      osc_auto = 1'b0;
      repeat (8) @(negedge clk);
      bus_wr(A_FLG, 'h01);
      rd_chk("R9 flag clear before race", A_FLG, 'h00);
      @(negedge clk); osc_man = 1'b1;         // sampled at edge E0
      @(negedge clk);                          // after E0
      addr = 9'(A_FLG); wdata = 'h01; wr = 1'b1; // clear lands at E2 with tick
      @(negedge clk);                          // after E1
      @(negedge clk);                          // after E2
      wr = 1'b0;
      rd_chk("R9 set wins over clear", A_FLG, 'h01);
      rd_chk("R5 R7 slow tick sampled", A_RES, 'h01);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_regs();
      t_gating();
      t_fast();
      t_recover();
      t_slow();
      t_priority();
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      n_run++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule